// File: doc/BRIEF.md
# APB UART Register Front End

This block is the register side of a UART that sits on an APB bus. Software sees a 20-byte window holding data, status, control, scaler and FIFO debug words. Only the low 8 address bits are decoded. Characters that arrive on a byte-stream input with valid/ready are buffered in a receive FIFO. Software pops them by reading the data word. Writing the data word sends the low byte out on a byte-stream output. A single interrupt output gives a one-cycle pulse when a byte is accepted or sent, provided the matching enable bit is set.

The serial shifter, baud-rate scaling, parity and framing checks and FIFO debug mode are outside this block. The scaler and FIFO debug words read as zero. There is no transmit FIFO, so the two transmit-empty status flags are always set. The bus never stalls: a transmit write that meets a busy output stream is dropped.

Top module: `apb_uart_regs`

## Requirements
- R1: After reset the control word (offset 0x08) reads 0, the receive FIFO is empty, the status word (offset 0x04) reads 0x0000_0006 (bit 1 TX shift empty and bit 2 TX FIFO empty set, all else clear) and `irq` is low.
- R2: An access at offset 0x00 and one at offset 0x03 both reach the data register, for reads (pop) and for writes (transmit).
- R3: A byte offered on `rx_valid`/`rx_data` is taken when `rx_ready` is high. `rx_ready` is low exactly when the FIFO holds DEPTH bytes. A taken byte enters the FIFO only while control bit 0 (receive enable) is 1; otherwise it is discarded.
- R4: A stored byte sets status bit 0 (data ready). Data reads return stored bytes oldest first, in bits 7:0 with bits 31:8 zero, and each read removes one byte.
- R5: Status bit 0 clears when the last byte is read. A data read of an empty FIFO returns 0 and changes nothing.
- R6: A data write drives `tx_valid` high with `tx_data` = write data bits 7:0 during its access phase, only while control bit 1 (transmit enable) is 1. A write made while `tx_ready` is low is dropped.
- R7: `irq` is high for exactly one cycle, in the cycle after a byte is stored with control bit 2 set, or after a byte is sent (`tx_valid` and `tx_ready`) with control bit 3 set. Otherwise it stays low.
- R8: Writes to the status word are ignored. The control word is written in full (all 32 bits) and reads back as written. The scaler (0x0C), FIFO debug (0x10) and unmapped offsets read 0 and ignore writes.
- R9: Status bit 8 (RX FIFO half) is set while the fill level is at least DEPTH/2. Status bit 10 (RX FIFO full) is set while the level equals DEPTH. Status bits 3 to 7 and 9 read 0.
- R10: A byte stored in the same cycle as a data read of a non-empty FIFO leaves the fill level unchanged, and status bit 0 stays set.
- R11: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address; low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Receive FIFO can take a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that every APB transfer has a setup cycle followed by exactly one access cycle, with `paddr` and `pwrite` held across both cycles. They also assume that DEPTH is a power of two, so the FIFO pointers wrap naturally. The bench's transfer task always issues that two-cycle sequence with `pready` permanently high. It holds `rx_valid` for only a single cycle per byte, so every FIFO push and pop that the assertions count matches exactly one stimulus event.

// File: rtl/uart_regs_pkg.sv
// Package: shared offsets, bit positions and the register-select type
// for the APB UART register front end.
package uart_regs_pkg;

    // Byte offsets inside the register window (low 8 address bits)
    localparam logic [7:0] OFS_DATA     = 8'h00;
    localparam logic [7:0] OFS_DATA_B   = 8'h03;
    localparam logic [7:0] OFS_STATUS   = 8'h04;
    localparam logic [7:0] OFS_CTRL     = 8'h08;
    localparam logic [7:0] OFS_SCALER   = 8'h0C;
    localparam logic [7:0] OFS_DEBUG    = 8'h10;

    // Status bit positions
    localparam int ST_RDY      = 0;
    localparam int ST_TSH_MT   = 1;
    localparam int ST_TFF_MT   = 2;
    localparam int ST_RX_HALF  = 8;
    localparam int ST_RX_FULL  = 10;

    // Control bit positions used by this block
    localparam int CT_RX_EN    = 0;
    localparam int CT_TX_EN    = 1;
    localparam int CT_RX_IE    = 2;
    localparam int CT_TX_IE    = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_STATUS,
        SEL_CTRL,
        SEL_SCALER,
        SEL_DEBUG
    } reg_sel_e;

endpackage

// File: rtl/uart_addr_decode.sv
// Module: uart_addr_decode
// Maps an APB byte address onto one register of the window.
// Assumes: ADDR_W >= 8; only the low 8 bits take part in the decode.
module uart_addr_decode
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    logic [7:0] low_addr;
    assign low_addr = addr_i[7:0];

    // Purpose: pick the register selected by the low address byte
    always_comb begin
        unique case (low_addr)
            OFS_DATA,
            OFS_DATA_B:  sel_o = SEL_DATA;
            OFS_STATUS:  sel_o = SEL_STATUS;
            OFS_CTRL:    sel_o = SEL_CTRL;
            OFS_SCALER:  sel_o = SEL_SCALER;
            OFS_DEBUG:   sel_o = SEL_DEBUG;
            default:     sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/uart_rx_fifo.sv
// Module: uart_rx_fifo
// Receive FIFO with level output and a first-word read view.
// Assumes: DEPTH is a power of two; the caller never pushes when full
// and never pops when empty. Push and pop in one cycle keep the level.
module uart_rx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [DATA_W-1:0]          din_i,
    input  logic                       pop_i,
    output logic [DATA_W-1:0]          head_o,
    output logic [$clog2(DEPTH):0]     level_o,
    output logic                       empty_o,
    output logic                       full_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;

    // Purpose: store an incoming byte at the write pointer
    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[wr_ptr] <= din_i;
        end
    end

    // Purpose: advance pointers and track the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= wr_ptr + 1'b1;
            if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_i, pop_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign level_o = count;
    assign empty_o = (count == '0);
    assign full_o  = (count == CNT_W'(DEPTH));

    // R3: the caller keeps pushes away from a full FIFO
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count < CNT_W'(DEPTH)));

    // R5: pops never hit an empty FIFO
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (count != '0));

    // R10: simultaneous push and pop keep the level
    a_r10_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (count == $past(count)));

    // R4: a lone push raises the level by one
    a_r4_level_up: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/uart_irq_pulse.sv
// Module: uart_irq_pulse
// Turns receive and transmit events into a registered interrupt pulse.
// Assumes: events are single-cycle strobes already qualified by the
// matching enable bit.
module uart_irq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_evt_i,
    input  logic tx_evt_i,
    output logic irq_o
);

    // Purpose: raise the line for the cycle after any event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= rx_evt_i | tx_evt_i;
        end
    end

    // R7: a pulse is always preceded by a qualifying event
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(rx_evt_i || tx_evt_i));

    // R7: with no event, the line drops after one cycle
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rx_evt_i && !tx_evt_i) |=> !irq_o);

endmodule

// File: rtl/apb_uart_regs.sv
// Module: apb_uart_regs (top)
// APB register front end of a UART: decode, control register, status
// word, receive FIFO, transmit byte stream and interrupt pulse.
// Assumes: APB transfers take one setup and one access cycle; the bus
// never waits (pready tied high); a transmit write meeting tx_ready low
// is dropped.
module apb_uart_regs
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DEPTH    = 16,
    parameter int PDATA_W  = 32,
    parameter int BYTE_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [PDATA_W-1:0] pwdata,
    output logic [PDATA_W-1:0] prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [BYTE_W-1:0]  rx_data,
    input  logic               rx_valid,
    output logic               rx_ready,
    output logic [BYTE_W-1:0]  tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               irq
);

    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);

    reg_sel_e            sel;
    logic                acc_wr;
    logic                acc_rd;
    logic [PDATA_W-1:0]  ctrl_q;
    logic [PDATA_W-1:0]  status_w;
    logic                fifo_push;
    logic                fifo_pop;
    logic [BYTE_W-1:0]   fifo_head;
    logic [CNT_W-1:0]    fifo_level;
    logic                fifo_empty;
    logic                fifo_full;
    logic                rx_evt;
    logic                tx_evt;

    uart_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr_i (paddr),
        .sel_o  (sel)
    );

    assign acc_wr = psel & penable & pwrite;
    assign acc_rd = psel & penable & ~pwrite;

    // Purpose: hold the fully writable control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (acc_wr && sel == SEL_CTRL) begin
            ctrl_q <= pwdata;
        end
    end

    // Receive side: stream is taken whenever there is room
    assign rx_ready  = ~fifo_full;
    assign fifo_push = rx_valid & rx_ready & ctrl_q[CT_RX_EN];
    assign fifo_pop  = acc_rd & (sel == SEL_DATA) & ~fifo_empty;

    uart_rx_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (fifo_push),
        .din_i   (rx_data),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .level_o (fifo_level),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    // Transmit side: one byte per enabled data write
    assign tx_valid = acc_wr & (sel == SEL_DATA) & ctrl_q[CT_TX_EN];
    assign tx_data  = pwdata[BYTE_W-1:0];

    assign rx_evt = fifo_push & ctrl_q[CT_RX_IE];
    assign tx_evt = tx_valid & tx_ready & ctrl_q[CT_TX_IE];

    uart_irq_pulse i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_evt_i (rx_evt),
        .tx_evt_i (tx_evt),
        .irq_o    (irq)
    );

    // Purpose: assemble the status word from the FIFO level
    always_comb begin
        status_w             = '0;
        status_w[ST_RDY]     = ~fifo_empty;
        status_w[ST_TSH_MT]  = 1'b1;
        status_w[ST_TFF_MT]  = 1'b1;
        status_w[ST_RX_HALF] = (fifo_level >= HALF_LVL);
        status_w[ST_RX_FULL] = fifo_full;
    end

    // Purpose: select read data for the addressed register
    always_comb begin
        prdata = '0;
        if (acc_rd) begin
            case (sel)
                SEL_DATA:   prdata = fifo_empty ? '0 : PDATA_W'(fifo_head);
                SEL_STATUS: prdata = status_w;
                SEL_CTRL:   prdata = ctrl_q;
                default:    prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // R1: the control word only moves on a control write
    a_r1_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && sel == SEL_CTRL) |=> $stable(ctrl_q));

    // R9: a full FIFO is also at least half full
    a_r9_full_has_half: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[ST_RX_FULL] |-> status_w[ST_RX_HALF]);

    // R5: once the last byte is popped, data ready drops
    a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !fifo_push && fifo_level == CNT_W'(1)) |=> !status_w[ST_RDY]);

    // R6: an outgoing byte only appears during a write access phase
    a_r6_tx_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (psel && penable && pwrite));

endmodule

// File: tb/test_apb_uart_regs.sv
// Bench for apb_uart_regs: a vector table walked by one loop, then
// directed tests for reception, transmission, flags and reset.
module test_apb_uart_regs;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic        cap_txv;
    logic [7:0]  cap_txd;
    logic        cap_irq;
    logic [31:0] rd;

    always #5 clk = ~clk;

    apb_uart_regs #(.DEPTH(DEPTH)) i_apb_uart_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
    );

    // Vector: {is_read, req_no, addr, wdata, expected}
    localparam int NV = 10;
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 4'd1,  8'h04, 32'h0,         32'h0000_0006},
        {1'b1, 4'd1,  8'h08, 32'h0,         32'h0000_0000},
        {1'b0, 4'd8,  8'h08, 32'h8000_10F0, 32'h0},
        {1'b1, 4'd8,  8'h08, 32'h0,         32'h8000_10F0},
        {1'b0, 4'd8,  8'h04, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd8,  8'h04, 32'h0,         32'h0000_0006},
        {1'b0, 4'd8,  8'h0C, 32'h0000_1234, 32'h0},
        {1'b1, 4'd8,  8'h0C, 32'h0,         32'h0},
        {1'b1, 4'd8,  8'h10, 32'h0,         32'h0},
        {1'b1, 4'd5,  8'h00, 32'h0,         32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One APB transfer; optional byte offered during the access phase
    task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                       input logic with_rx, input logic [7:0] rxb,
                       output logic [31:0] rdv);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        @(negedge clk);
        penable = 1'b1;
        if (with_rx) begin rx_valid = 1'b1; rx_data = rxb; end
        #1;
        rdv = prdata; cap_txv = tx_valid; cap_txd = tx_data;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rx_valid = 1'b0;
        cap_irq = irq;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] dummy;
        apb(1'b1, a, wd, 1'b0, 8'h0, dummy);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
        apb(1'b0, a, 32'h0, 1'b0, 8'h0, v);
    endtask

    // Offer one byte for one cycle; cap_irq holds irq afterwards
    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
        cap_irq = irq;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values at the ports
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R11 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);

        // Table walk: R1, R8, R5 register map behaviour
        for (int i = 0; i < NV; i++) begin
            logic [76:0] v;
            v = VEC[i];
            if (v[76]) begin
                rd_reg(v[71:64], rd);
                chk($sformatf("R%0d vector %0d", v[75:72], i), rd, v[31:0]);
            end else begin
                wr_reg(v[71:64], v[63:32]);
            end
        end

        // R3: receive disabled -> byte discarded
        wr_reg(8'h08, 32'h0);
        push_byte(8'h11);
        rd_reg(8'h04, rd);
        chk("R3 rx disabled discards", rd, 32'h6);

        // R7/R4: rx enable + rx irq enable
        wr_reg(8'h08, 32'h5);
        push_byte(8'hA5);
        chk("R7 rx irq pulse high", {31'b0, cap_irq}, 32'h1);
        @(negedge clk);
        chk("R7 rx irq pulse one cycle", {31'b0, irq}, 32'h0);
        rd_reg(8'h04, rd);
        chk("R4 data ready set", rd, 32'h7);
        push_byte(8'h3C);
        rd_reg(8'h00, rd);
        chk("R4 oldest first", rd, 32'hA5);
        rd_reg(8'h03, rd);
        chk("R2 byte-offset data read", rd, 32'h3C);
        rd_reg(8'h04, rd);
        chk("R5 data ready clears", rd, 32'h6);
        rd_reg(8'h00, rd);
        chk("R5 empty read zero", rd, 32'h0);

        // R9 / R3: fill to the top with rx irq off
        wr_reg(8'h08, 32'h1);
        push_byte(8'h80);
        chk("R7 no irq when disabled", {31'b0, cap_irq}, 32'h0);
        for (int k = 1; k < DEPTH / 2; k++) push_byte(8'h80 + 8'(k));
        rd_reg(8'h04, rd);
        chk("R9 half flag", rd, 32'h107);
        for (int k = DEPTH / 2; k < DEPTH; k++) push_byte(8'h80 + 8'(k));
        rd_reg(8'h04, rd);
        chk("R9 full flag", rd, 32'h507);
        chk("R3 rx_ready low when full", {31'b0, rx_ready}, 32'h0);
        push_byte(8'hEE);
        for (int k = 0; k < DEPTH; k++) begin
            rd_reg(8'h00, rd);
            chk("R4 drain order", rd, 32'h80 + 32'(k));
        end
        rd_reg(8'h04, rd);
        chk("R3 extra byte refused", rd, 32'h6);

        // R10: push and pop together
        push_byte(8'h40);
        apb(1'b0, 8'h00, 32'h0, 1'b1, 8'h41, rd);
        chk("R10 pop during push", rd, 32'h40);
        rd_reg(8'h04, rd);
        chk("R10 data ready kept", rd, 32'h7);
        rd_reg(8'h00, rd);
        chk("R10 pushed byte kept", rd, 32'h41);

        // R6/R7: transmit with tx irq
        wr_reg(8'h08, 32'hA);
        tx_ready = 1'b1;
        apb(1'b1, 8'h00, 32'h0000_01C3, 1'b0, 8'h0, rd);
        chk("R6 tx valid", {31'b0, cap_txv}, 32'h1);
        chk("R6 tx low byte", {24'b0, cap_txd}, 32'hC3);
        chk("R7 tx irq pulse", {31'b0, cap_irq}, 32'h1);
        apb(1'b1, 8'h03, 32'h0000_005A, 1'b0, 8'h0, rd);
        chk("R2 byte-offset data write", {23'b0, cap_txv, cap_txd}, 32'h15A);
        tx_ready = 1'b0;
        apb(1'b1, 8'h00, 32'h0000_0077, 1'b0, 8'h0, rd);
        chk("R6 dropped when busy: no irq", {31'b0, cap_irq}, 32'h0);
        tx_ready = 1'b1;
        wr_reg(8'h08, 32'h8);
        apb(1'b1, 8'h00, 32'h0000_0099, 1'b0, 8'h0, rd);
        chk("R6 tx disabled", {30'b0, cap_txv, cap_irq}, 32'h0);

        // R1: reset in the middle of activity
        wr_reg(8'h08, 32'h5);
        push_byte(8'h12);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        rd_reg(8'h04, rd);
        chk("R1 status after reset", rd, 32'h6);
        rd_reg(8'h08, rd);
        chk("R1 control after reset", rd, 32'h0);
        chk("R11 pready/pslverr end", {30'b0, pready, pslverr}, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule